// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block drives the streaming word-program mode of a serial flash controller. An SPI front end decodes each command into strobes: an opcode strobe, an address strobe and one strobe per data byte. It also gives a single end-of-command pulse when chip select returns high. The sequencer gathers each frame and acts on it at that pulse.

The first streaming command needs the write-enable latch already set. It supplies an even start address and two data bytes, and the sequencer issues a word write for them. Each later streaming command supplies only a byte pair, which goes to the next word address taken from an internal pointer. While the mode is active, only the streaming opcode and the write-disable opcode have any effect. Write-disable leaves the mode. Between commands the sequencer can present a ready/busy level on the serial data-out pin.

The array reports the end of each word write with a done pulse. A protection window can be applied: a word inside it is skipped and the stream carries on.

Top module: `aai_seq`

## Requirements
- R1: After reset, wel, aai_active, busy, wr_req and so_oe are all 0.
- R2: Outside streaming mode, opcode 06h sets wel and opcode 04h clears it. Each takes effect at the end-of-command pulse.
- R3: Opcode ADh enters streaming mode when all of these hold: wel=1, the frame carried an address with bit 0 equal to 0, and exactly two data bytes followed. On entry the sequencer pulses wr_req for one cycle, with wr_addr set to the start address and wr_data set to {second byte, first byte}, and aai_active becomes 1.
- R4: An ADh frame with wel=0, or with an odd address, changes no state and issues no write.
- R5: In streaming mode, each ADh frame with exactly two data bytes writes to the word 2 bytes above the previous word, whether that previous word was written or skipped.
- R6: In streaming mode, every opcode other than ADh and 04h is ignored. This includes 06h, 70h, 80h and read opcodes, and the word pointer does not move.
- R7: Opcode 04h in streaming mode clears both wel and aai_active.
- R8: busy rises together with wr_req and stays high until a prog_done pulse. An ADh frame that ends while busy=1 is dropped and the pointer does not move.
- R9: Opcode 70h outside streaming mode enables busy routing, and 80h outside streaming mode disables it. With routing enabled, aai_active=1 and cs_n=1, the block drives so_oe=1 with so_level equal to the inverse of busy. With cs_n=0, so_oe=0.
- R10: In streaming mode, a word whose byte address is at or above prot_floor while prot_en=1 gets no wr_req and does not set busy. The pointer still advances, and wel and aai_active are unchanged.
- R11: When the word at the top of the address space (byte address with all bits 1 except bit 0) is written or skipped, aai_active and wel both clear.
- R12: An ADh frame with fewer or more than two data bytes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level from the serial pins |
| op_stb | input | 1 | Opcode byte received |
| op_code | input | 8 | Opcode value |
| addr_stb | input | 1 | Full address received |
| addr_in | input | ADDR_W | Byte address |
| byte_stb | input | 1 | Data byte received |
| byte_in | input | 8 | Data byte value |
| cmd_end | input | 1 | One-cycle pulse at the chip-select rise that ends a frame |
| prog_done | input | 1 | Array finished the current word write |
| prot_en | input | 1 | Protection window active |
| prot_floor | input | ADDR_W | Lowest protected byte address |
| wr_req | output | 1 | One-cycle word write request |
| wr_addr | output | ADDR_W | Even byte address of the word |
| wr_data | output | 16 | Word data, low byte at the even address |
| wel | output | 1 | Write-enable latch |
| aai_active | output | 1 | Streaming-mode status bit |
| busy | output | 1 | Word write in progress |
| so_oe | output | 1 | Drive enable for the data-out pin |
| so_level | output | 1 | Ready (1) or busy (0) level for the data-out pin |

## Verification
The assertions check several properties on every cycle. The latch can only rise outside streaming mode, the mode can only be entered with the latch set, and leaving the mode always leaves the latch clear. Busy rises with each write request and holds until the done pulse, and the data-out pin is driven only with chip select high during the mode. The bench scenarios cover the rest: the pointer sequence, byte order, dropped frames while busy, skipped protected words, the exit at the top word, and the routing on and off. In those scenarios each frame is compared with a model of the requirements, in directed cases and in a seeded random stream of mixed opcodes and byte counts.

// File: rtl/aai_pkg.sv
`timescale 1ns/1ps
package aai_pkg;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_EBSY = 8'h70;
  localparam logic [7:0] OP_DBSY = 8'h80;
  localparam logic [7:0] OP_AAI  = 8'hAD;

  localparam int LANES = 2;

  typedef struct packed {
    logic [7:0]         op;
    logic               has_addr;
    logic               pair;
    logic [8*LANES-1:0] data;
  } aai_frame_t;
endpackage

// File: rtl/aai_frame_capture.sv
`timescale 1ns/1ps
module aai_frame_capture #(
  parameter int ADDR_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_stb,
  input  logic [7:0]         op_code,
  input  logic               addr_stb,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic               byte_stb,
  input  logic [7:0]         byte_in,
  output aai_pkg::aai_frame_t frm,
  output logic [ADDR_W-1:0]  f_addr
);
  import aai_pkg::*;

  logic [7:0]        op_q, op_d;
  logic              ha_q, ha_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [8*LANES-1:0] lanes;

  always_comb begin
    op_d  = op_q;
    ha_d  = ha_q;
    cnt_d = cnt_q;
    adr_d = adr_q;
    if (op_stb) begin
      op_d  = op_code;
      ha_d  = 1'b0;
      cnt_d = 2'd0;
    end else begin
      if (addr_stb) begin
        adr_d = addr_in;
        ha_d  = 1'b1;
      end
      if (byte_stb && cnt_q != 2'd3) cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= 8'h00;
      ha_q  <= 1'b0;
      cnt_q <= 2'd0;
      adr_q <= '0;
    end else begin
      op_q  <= op_d;
      ha_q  <= ha_d;
      cnt_q <= cnt_d;
      adr_q <= adr_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    always_comb begin
      lane_d = lane_q;
      if (byte_stb && !op_stb && cnt_q == 2'(g)) lane_d = byte_in;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= 8'h00;
      else        lane_q <= lane_d;
    end
    assign lanes[8*g +: 8] = lane_q;
  end

  assign frm.op       = op_q;
  assign frm.has_addr = ha_q;
  assign frm.pair     = (cnt_q == 2'(LANES));
  assign frm.data     = lanes;
  assign f_addr       = adr_q;
endmodule

// File: rtl/aai_word_ptr.sv
`timescale 1ns/1ps
module aai_word_ptr #(
  parameter int WIDX_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic [WIDX_W-1:0] start_idx,
  input  logic              adv,
  output logic [WIDX_W-1:0] tgt,
  output logic              tgt_top
);
  logic [WIDX_W-1:0] ptr_q, ptr_d;

  assign tgt     = sel_start ? start_idx : ptr_q;
  assign tgt_top = &tgt;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = tgt + WIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/aai_ryby_out.sv
`timescale 1ns/1ps
module aai_ryby_out (
  input  logic route_en,
  input  logic aai_on,
  input  logic cs_n,
  input  logic busy,
  output logic so_oe,
  output logic so_level
);
  assign so_oe    = route_en && aai_on && cs_n;
  assign so_level = !busy;
endmodule

// File: rtl/aai_seq.sv
`timescale 1ns/1ps
module aai_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              op_stb,
  input  logic [7:0]        op_code,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              cmd_end,
  input  logic              prog_done,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] prot_floor,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              wel,
  output logic              aai_active,
  output logic              busy,
  output logic              so_oe,
  output logic              so_level
);
  import aai_pkg::*;

  localparam int WIDX_W = ADDR_W - 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  aai_frame_t        frm;
  logic [ADDR_W-1:0] f_addr;

  aai_frame_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(srst_n),
    .op_stb(op_stb), .op_code(op_code),
    .addr_stb(addr_stb), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in),
    .frm(frm), .f_addr(f_addr)
  );

  logic wel_q, wel_d, aai_q, aai_d, route_q, route_d, busy_q, busy_d;
  logic req_q, req_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [15:0]       wdata_q, wdata_d;

  logic aai_pkt, first_ok, cont_ok, issue, prot_hit, at_top;
  logic [WIDX_W-1:0] tgt;

  assign aai_pkt  = cmd_end && frm.op == OP_AAI && frm.pair && !busy_q;
  assign first_ok = aai_pkt && !aai_q && wel_q && frm.has_addr && !f_addr[0];
  assign cont_ok  = aai_pkt && aai_q;
  assign issue    = first_ok || cont_ok;

  aai_word_ptr #(.WIDX_W(WIDX_W)) u_ptr (
    .clk(clk), .rst_n(srst_n),
    .sel_start(!aai_q), .start_idx(f_addr[ADDR_W-1:1]),
    .adv(issue), .tgt(tgt), .tgt_top(at_top)
  );

  assign prot_hit = prot_en && ({tgt, 1'b0} >= prot_floor);

  always_comb begin
    wel_d   = wel_q;
    aai_d   = aai_q;
    route_d = route_q;
    req_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (cmd_end) begin
      if (aai_q) begin
        if (frm.op == OP_WRDI) begin
          wel_d = 1'b0;
          aai_d = 1'b0;
        end else if (cont_ok && at_top) begin
          wel_d = 1'b0;
          aai_d = 1'b0;
        end
      end else begin
        case (frm.op)
          OP_WREN: wel_d   = 1'b1;
          OP_WRDI: wel_d   = 1'b0;
          OP_EBSY: route_d = 1'b1;
          OP_DBSY: route_d = 1'b0;
          default: ;
        endcase
        if (first_ok) begin
          aai_d = !at_top;
          if (at_top) wel_d = 1'b0;
        end
      end
    end
    if (issue && !prot_hit) begin
      req_d   = 1'b1;
      waddr_d = {tgt, 1'b0};
      wdata_d = frm.data;
    end
    if (req_d)          busy_d = 1'b1;
    else if (prog_done) busy_d = 1'b0;
    else                busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wel_q   <= 1'b0;
      aai_q   <= 1'b0;
      route_q <= 1'b0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= 16'h0000;
    end else begin
      wel_q   <= wel_d;
      aai_q   <= aai_d;
      route_q <= route_d;
      busy_q  <= busy_d;
      req_q   <= req_d;
      if (req_d) begin
        waddr_q <= waddr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  aai_ryby_out u_ry (
    .route_en(route_q), .aai_on(aai_q), .cs_n(cs_n), .busy(busy_q),
    .so_oe(so_oe), .so_level(so_level)
  );

  assign wr_req     = req_q;
  assign wr_addr    = waddr_q;
  assign wr_data    = wdata_q;
  assign wel        = wel_q;
  assign aai_active = aai_q;
  assign busy       = busy_q;
endmodule

// File: rtl/aai_seq_chk.sv
`timescale 1ns/1ps
module aai_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic prog_done,
  input logic wr_req,
  input logic wel,
  input logic aai_active,
  input logic busy,
  input logic so_oe
);
  // R6
  wel_rise_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(aai_active));

  // R3
  entry_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_active) |-> $past(wel));

  // R7
  exit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai_active) |-> !wel);

  // R8
  req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $rose(busy));

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy);

  // R9
  so_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (cs_n && aai_active));
endmodule

bind aai_seq aai_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prog_done(prog_done),
  .wr_req(wr_req), .wel(wel), .aai_active(aai_active), .busy(busy),
  .so_oe(so_oe)
);

// File: tb/aai_seq_test.sv
`timescale 1ns/1ps
module aai_seq_test;
  localparam int AW = 18;
  localparam logic [7:0] WRDI = 8'h04, WREN = 8'h06, EBSY = 8'h70,
                         DBSY = 8'h80, AAI = 8'hAD, RD = 8'h03;

  logic clk = 1'b0;
  logic rst_n, cs_n, op_stb, addr_stb, byte_stb, cmd_end, prog_done, prot_en;
  logic [7:0] op_code, byte_in;
  logic [AW-1:0] addr_in, prot_floor, wr_addr;
  logic [15:0] wr_data;
  logic wr_req, wel, aai_active, busy, so_oe, so_level;

  always #2.5 clk = ~clk;

  aai_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_stb(op_stb), .op_code(op_code),
    .addr_stb(addr_stb), .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
    .cmd_end(cmd_end), .prog_done(prog_done), .prot_en(prot_en),
    .prot_floor(prot_floor), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wel(wel), .aai_active(aai_active), .busy(busy), .so_oe(so_oe), .so_level(so_level)
  );

  int total = 0, fails = 0;
  bit done = 0;

  bit m_wel, m_aai, m_busy, m_route, m_prot;
  logic [AW-1:0] m_ptr, m_floor;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] op, input bit ha, input logic [AW-1:0] a,
                       input int n, input logic [7:0] b0, input logic [7:0] b1,
                       output bit er, output logic [AW-1:0] ea, output logic [15:0] ed);
    bit pk, first, cont;
    logic [AW-1:0] t;
    pk    = (op == AAI) && (n == 2) && !m_busy;
    first = pk && !m_aai && m_wel && ha && !a[0];
    cont  = pk && m_aai;
    er = 0; ea = '0; ed = '0;
    if (m_aai) begin
      if (op == WRDI) begin m_wel = 0; m_aai = 0; end
    end else begin
      if (op == WREN) m_wel = 1;
      if (op == WRDI) m_wel = 0;
      if (op == EBSY) m_route = 1;
      if (op == DBSY) m_route = 0;
    end
    if (first || cont) begin
      t  = first ? a : m_ptr;
      er = !(m_prot && t >= m_floor);
      ea = t; ed = {b1, b0};
      if (first) m_aai = 1;
      if (t == {{(AW-1){1'b1}}, 1'b0}) begin m_aai = 0; m_wel = 0; end
      m_ptr = t + 2;
      if (er) m_busy = 1;
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input bit ha, input logic [AW-1:0] a,
                        input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input string tag);
    bit er; logic [AW-1:0] ea; logic [15:0] ed;
    @(negedge clk); cs_n = 0; op_stb = 1; op_code = op;
    @(negedge clk); op_stb = 0;
    if (ha) begin addr_stb = 1; addr_in = a; @(negedge clk); addr_stb = 0; end
    for (int i = 0; i < n; i++) begin
      byte_stb = 1; byte_in = (i == 0) ? b0 : (i == 1) ? b1 : 8'h5A;
      @(negedge clk); byte_stb = 0;
    end
    cs_n = 1; cmd_end = 1;
    @(negedge clk); cmd_end = 0;
    model(op, ha, a, n, b0, b1, er, ea, ed);
    check({tag, " wr_req"}, 32'(wr_req), 32'(er));
    if (er) begin
      check({tag, " wr_addr"}, 32'(wr_addr), 32'(ea));
      check({tag, " wr_data"}, 32'(wr_data), 32'(ed));
    end
    check({tag, " wel"}, 32'(wel), 32'(m_wel));
    check({tag, " aai"}, 32'(aai_active), 32'(m_aai));
    check({tag, " busy"}, 32'(busy), 32'(m_busy));
    check({tag, " so_oe"}, 32'(so_oe), 32'(m_route && m_aai));
  endtask

  task automatic finish_prog(input string tag);
    @(negedge clk); prog_done = 1;
    @(negedge clk); prog_done = 0;
    m_busy = 0;
    check({tag, " busy clear"}, 32'(busy), 32'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 0; cs_n = 1; op_stb = 0; addr_stb = 0; byte_stb = 0; cmd_end = 0;
    prog_done = 0; prot_en = 0; op_code = 0; byte_in = 0; addr_in = 0;
    prot_floor = '0;
    m_wel = 0; m_aai = 0; m_busy = 0; m_route = 0; m_prot = 0; m_ptr = '0; m_floor = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wel", 32'(wel), 0);
    check("R1 aai", 32'(aai_active), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 wr_req", 32'(wr_req), 0);
    check("R1 so_oe", 32'(so_oe), 0);

    // R2 latch set and clear
    do_cmd(WREN, 0, 0, 0, 0, 0, "R2 wren");
    do_cmd(WRDI, 0, 0, 0, 0, 0, "R2 wrdi");
    // R4 no latch, then odd address
    do_cmd(AAI, 1, 18'h00100, 2, 8'h11, 8'h22, "R4 nowel");
    do_cmd(WREN, 0, 0, 0, 0, 0, "R2 wren2");
    do_cmd(AAI, 1, 18'h00101, 2, 8'h11, 8'h22, "R4 odd");
    // R3 entry
    do_cmd(AAI, 1, 18'h00100, 2, 8'h11, 8'h22, "R3 entry");
    // R8 dropped while busy
    do_cmd(AAI, 0, 0, 2, 8'h33, 8'h44, "R8 busydrop");
    finish_prog("R8");
    // R5 next word
    do_cmd(AAI, 0, 0, 2, 8'h55, 8'h66, "R5 next");
    finish_prog("R5");
    // R6 ignored opcodes
    do_cmd(WREN, 0, 0, 0, 0, 0, "R6 wren");
    do_cmd(EBSY, 0, 0, 0, 0, 0, "R6 ebsy");
    do_cmd(RD, 1, 18'h00000, 0, 0, 0, "R6 read");
    do_cmd(AAI, 0, 0, 2, 8'h77, 8'h88, "R6 ptr");
    finish_prog("R6");
    // R12 wrong byte counts
    do_cmd(AAI, 0, 0, 1, 8'h99, 8'h00, "R12 one");
    do_cmd(AAI, 0, 0, 3, 8'h99, 8'hAA, "R12 three");
    do_cmd(AAI, 0, 0, 2, 8'hBB, 8'hCC, "R12 after");
    finish_prog("R12");
    // R7 exit
    do_cmd(WRDI, 0, 0, 0, 0, 0, "R7 exit");

    // R9 busy routing
    do_cmd(EBSY, 0, 0, 0, 0, 0, "R9 ebsy");
    do_cmd(WREN, 0, 0, 0, 0, 0, "R9 wren");
    do_cmd(AAI, 1, 18'h00200, 2, 8'h01, 8'h02, "R9 entry");
    check("R9 so_level busy", 32'(so_level), 0);
    @(negedge clk); cs_n = 0;
    @(negedge clk);
    check("R9 so_oe cs low", 32'(so_oe), 0);
    cs_n = 1;
    finish_prog("R9");
    check("R9 so_oe ready", 32'(so_oe), 1);
    check("R9 so_level ready", 32'(so_level), 1);
    do_cmd(WRDI, 0, 0, 0, 0, 0, "R9 wrdi");
    do_cmd(DBSY, 0, 0, 0, 0, 0, "R9 dbsy");
    do_cmd(WREN, 0, 0, 0, 0, 0, "R9 wren2");
    do_cmd(AAI, 1, 18'h00240, 2, 8'h03, 8'h04, "R9 off");
    finish_prog("R9b");
    do_cmd(WRDI, 0, 0, 0, 0, 0, "R9 wrdi2");

    // R10 protected words
    prot_en = 1; prot_floor = 18'h00300; m_prot = 1; m_floor = 18'h00300;
    do_cmd(WREN, 0, 0, 0, 0, 0, "R10 wren");
    do_cmd(AAI, 1, 18'h002FE, 2, 8'h10, 8'h20, "R10 below");
    finish_prog("R10");
    do_cmd(AAI, 0, 0, 2, 8'h30, 8'h40, "R10 skip1");
    do_cmd(AAI, 0, 0, 2, 8'h50, 8'h60, "R10 skip2");
    prot_en = 0; m_prot = 0;
    do_cmd(AAI, 0, 0, 2, 8'h70, 8'h80, "R10 resume");
    finish_prog("R10b");
    do_cmd(WRDI, 0, 0, 0, 0, 0, "R10 wrdi");

    // R11 top of array
    do_cmd(WREN, 0, 0, 0, 0, 0, "R11 wren");
    do_cmd(AAI, 1, 18'h3FFFC, 2, 8'hE1, 8'hE2, "R11 near");
    finish_prog("R11");
    do_cmd(AAI, 0, 0, 2, 8'hE3, 8'hE4, "R11 top");
    finish_prog("R11b");

    // random stream
    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      int sel, n;
      bit ha;
      logic [AW-1:0] a;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1:    op = WREN;
        2:       op = WRDI;
        3:       op = EBSY;
        4:       op = DBSY;
        5:       op = RD;
        default: op = AAI;
      endcase
      ha = ($urandom_range(0, 3) != 0);
      a = AW'($urandom_range(0, 32'h3FFFF));
      if ($urandom_range(0, 3) != 0) a[0] = 1'b0;
      if ($urandom_range(0, 15) == 0) a = 18'h3FFFA;
      n = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 3)) : 2;
      do_cmd(op, ha, a, n, 8'($urandom), 8'($urandom), "R5 random");
      if (busy && $urandom_range(0, 2) != 0) finish_prog("R8 random");
    end

    done = 1;
    summary();
  end
endmodule